// File: doc/BRIEF.md
# Bidirectional Parity-Checked Bus Transceiver

This block joins two byte-wide bus ports, A and B, and passes data between them in one direction at a time. A direction input picks transmit (A data appears on B) or receive (B data appears on A), and a float input releases every driven pin at once. It is purely combinational: every output follows its inputs within the same cycle.

Alongside the data, a single parity pin turns around with the bus. While transmitting, the block generates a parity bit from port A and drives it. While receiving, it takes the parity bit in, compares it with the parity it would have generated from port B, and drives a check flag that is HIGH when the two agree and LOW on a mismatch. A select input sets the parity sense: HIGH gives a parity bit that is HIGH for an even count of ones, LOW gives one that is HIGH for an odd count. Each pin that can float is presented as a separate input, output value and drive enable, so the pad ring owns the actual tristate buffers.

Top module: `xcvr_parity_bus`

## Requirements
- R1: With float_i LOW and dir_tx_i HIGH, b_oe_o is 1 and b_out_o equals a_in_i bit for bit.
- R2: With float_i LOW and dir_tx_i LOW, a_oe_o is 1 and a_out_o equals b_in_i bit for bit.
- R3: With float_i HIGH, a_oe_o, b_oe_o, par_oe_o and chk_oe_o are all 0 whatever the other inputs are.
- R4: With float_i LOW and dir_tx_i HIGH, par_oe_o is 1 and par_out_o is 1 exactly when odd_sel_i is 1 and a_in_i holds an even count of ones (0, 2, 4, 6 or 8), or odd_sel_i is 0 and the count is odd.
- R5: With float_i LOW and dir_tx_i LOW, chk_oe_o is 1 and chk_ok_o is 1 exactly when par_in_i equals the parity R4 would give for b_in_i under the current odd_sel_i; otherwise chk_ok_o is 0.
- R6: In transmit, chk_oe_o is 0, and b_in_i and par_in_i have no effect on b_out_o or par_out_o.
- R7: In receive, par_oe_o and b_oe_o are 0, and a_in_i has no effect on a_out_o or chk_ok_o.
- R8: a_oe_o and b_oe_o are never 1 together, and par_oe_o and chk_oe_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| float_i | input | 1 | HIGH releases all driven pins |
| dir_tx_i | input | 1 | HIGH: A to B with parity generation; LOW: B to A with parity check |
| odd_sel_i | input | 1 | Parity sense select |
| a_in_i | input | 8 | Value seen on port A pins |
| a_out_o | output | 8 | Value to drive on port A |
| a_oe_o | output | 1 | Drive enable for port A |
| b_in_i | input | 8 | Value seen on port B pins |
| b_out_o | output | 8 | Value to drive on port B |
| b_oe_o | output | 1 | Drive enable for port B |
| par_in_i | input | 1 | Value seen on the parity pin |
| par_out_o | output | 1 | Generated parity to drive |
| par_oe_o | output | 1 | Drive enable for the parity pin |
| chk_ok_o | output | 1 | Check flag, HIGH means parity agrees |
| chk_oe_o | output | 1 | Drive enable for the check flag |

## Verification
The parity generator on A and the parity checker on B both evaluate in every cycle, so a direction flip in the same cycle as a change of data or parity sense exercises both at once. The bench provokes this by changing the direction together with the data on both ports, the parity input and the select in one step, and then judges that only the path belonging to the new direction is driven and correct while the idle path leaves no trace on the driven outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic port_a;
    logic port_b;
    logic par;
    logic chk;
  } drive_t;
endpackage

// File: rtl/xcvr_xor_tree.sv
module xcvr_xor_tree #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  output logic             odd_o
);
  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned LEAVES = 1 << LEVELS;

  // heap-ordered nodes: node k combines nodes 2k and 2k+1, leaves at LEAVES..
  logic [2*LEAVES-1:1] node;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < WIDTH) begin : g_data
      assign node[LEAVES+i] = data_i[i];
    end else begin : g_pad
      assign node[LEAVES+i] = 1'b0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign node[k] = node[2*k] ^ node[2*k+1];
  end

  assign odd_o = node[1];
endmodule

// File: rtl/xcvr_parity_gen.sv
module xcvr_parity_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             odd_sel_i,
  output logic             par_o
);
  logic odd_cnt;

  xcvr_xor_tree #(.WIDTH(WIDTH)) u_tree (
    .data_i (data_i),
    .odd_o  (odd_cnt)
  );

  // select HIGH: bit set for an even count; select LOW: set for an odd count
  assign par_o = odd_cnt ^ odd_sel_i;
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic   float_i,
  input  logic   dir_tx_i,
  output drive_t drv_o
);
  logic active;

  always_comb begin
    active       = ~float_i;
    drv_o.port_b = active &  dir_tx_i;
    drv_o.par    = active &  dir_tx_i;
    drv_o.port_a = active & ~dir_tx_i;
    drv_o.chk    = active & ~dir_tx_i;
  end
endmodule

// File: rtl/xcvr_parity_bus.sv
module xcvr_parity_bus
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              float_i,
  input  logic              dir_tx_i,
  input  logic              odd_sel_i,
  input  logic [DATA_W-1:0] a_in_i,
  output logic [DATA_W-1:0] a_out_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_in_i,
  output logic [DATA_W-1:0] b_out_o,
  output logic              b_oe_o,
  input  logic              par_in_i,
  output logic              par_out_o,
  output logic              par_oe_o,
  output logic              chk_ok_o,
  output logic              chk_oe_o
);
  drive_t drv;
  logic   par_from_a;
  logic   par_from_b;

  xcvr_dir_ctrl u_dir (
    .float_i  (float_i),
    .dir_tx_i (dir_tx_i),
    .drv_o    (drv)
  );

  xcvr_parity_gen #(.WIDTH(DATA_W)) u_gen_a (
    .data_i    (a_in_i),
    .odd_sel_i (odd_sel_i),
    .par_o     (par_from_a)
  );

  xcvr_parity_gen #(.WIDTH(DATA_W)) u_gen_b (
    .data_i    (b_in_i),
    .odd_sel_i (odd_sel_i),
    .par_o     (par_from_b)
  );

  always_comb begin
    b_out_o   = a_in_i;
    a_out_o   = b_in_i;
    par_out_o = par_from_a;
    chk_ok_o  = ~(par_from_b ^ par_in_i);
    a_oe_o    = drv.port_a;
    b_oe_o    = drv.port_b;
    par_oe_o  = drv.par;
    chk_oe_o  = drv.chk;
  end
endmodule

// File: rtl/xcvr_parity_bus_chk.sv
module xcvr_parity_bus_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              float_i,
  input logic              dir_tx_i,
  input logic              odd_sel_i,
  input logic [DATA_W-1:0] a_in_i,
  input logic [DATA_W-1:0] a_out_o,
  input logic              a_oe_o,
  input logic [DATA_W-1:0] b_in_i,
  input logic [DATA_W-1:0] b_out_o,
  input logic              b_oe_o,
  input logic              par_in_i,
  input logic              par_out_o,
  input logic              par_oe_o,
  input logic              chk_ok_o,
  input logic              chk_oe_o
);
  logic a_even;
  logic b_even;

  always_comb begin
    a_even = ($countones(a_in_i) % 2) == 0;
    b_even = ($countones(b_in_i) % 2) == 0;

    assert_tx_copy_R1: assert (!b_oe_o || (b_out_o == a_in_i));
    assert_rx_copy_R2: assert (!a_oe_o || (a_out_o == b_in_i));
    assert_float_R3: assert (!float_i || !(a_oe_o || b_oe_o || par_oe_o || chk_oe_o));
    assert_gen_R4: assert (!par_oe_o || (par_out_o == (odd_sel_i ? a_even : !a_even)));
    assert_check_R5: assert (!chk_oe_o ||
      (chk_ok_o == (par_in_i == (odd_sel_i ? b_even : !b_even))));
    assert_tx_no_chk_R6: assert (float_i || !dir_tx_i || !chk_oe_o);
    assert_rx_no_b_R7: assert (float_i || dir_tx_i || (!par_oe_o && !b_oe_o));
    assert_no_fight_R8: assert (!(a_oe_o && b_oe_o) && !(par_oe_o && chk_oe_o));
  end
endmodule

bind xcvr_parity_bus xcvr_parity_bus_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_xcvr_parity_bus.sv
`timescale 1ns/1ps
module sim_xcvr_parity_bus;
  localparam int W = 8;

  logic clk;
  logic rst_n;
  logic float_i, dir_tx_i, odd_sel_i, par_in_i;
  logic [W-1:0] a_in_i, b_in_i;
  logic [W-1:0] a_out_o, b_out_o;
  logic a_oe_o, b_oe_o, par_out_o, par_oe_o, chk_ok_o, chk_oe_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  xcvr_parity_bus #(.DATA_W(W)) u0 (
    .float_i(float_i), .dir_tx_i(dir_tx_i), .odd_sel_i(odd_sel_i),
    .a_in_i(a_in_i), .a_out_o(a_out_o), .a_oe_o(a_oe_o),
    .b_in_i(b_in_i), .b_out_o(b_out_o), .b_oe_o(b_oe_o),
    .par_in_i(par_in_i), .par_out_o(par_out_o), .par_oe_o(par_oe_o),
    .chk_ok_o(chk_ok_o), .chk_oe_o(chk_oe_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic ref_par(input logic [W-1:0] d, input logic sel);
    int n = 0;
    for (int i = 0; i < W; i++) n += d[i];
    return sel ? ((n % 2) == 0) : ((n % 2) == 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (fl=%0b tx=%0b sel=%0b a=%0h b=%0h p=%0b)",
               tag, act, exp, float_i, dir_tx_i, odd_sel_i, a_in_i, b_in_i, par_in_i);
    end
  endtask

  // drive after a rising edge, judge at the following falling edge
  task automatic apply(input logic fl, input logic tx, input logic sel,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    @(posedge clk);
    float_i = fl; dir_tx_i = tx; odd_sel_i = sel;
    a_in_i = a; b_in_i = b; par_in_i = p;
    @(negedge clk);
    judge();
  endtask

  task automatic judge();
    logic en_oe;
    en_oe = ~float_i;
    chk(!(a_oe_o && b_oe_o) && !(par_oe_o && chk_oe_o), "R8", {4'b0, a_oe_o, b_oe_o, par_oe_o, chk_oe_o}, 8'h0);
    if (float_i) begin
      chk({a_oe_o, b_oe_o, par_oe_o, chk_oe_o} == 4'b0, "R3",
          {4'b0, a_oe_o, b_oe_o, par_oe_o, chk_oe_o}, 8'h0);
    end else if (dir_tx_i) begin
      chk(b_oe_o && b_out_o == a_in_i, "R1", b_out_o, a_in_i);
      chk(par_oe_o && par_out_o == ref_par(a_in_i, odd_sel_i), "R4",
          {7'b0, par_out_o}, {7'b0, ref_par(a_in_i, odd_sel_i)});
      chk(!chk_oe_o && !a_oe_o, "R6", {6'b0, chk_oe_o, a_oe_o}, 8'h0);
    end else begin
      chk(a_oe_o && a_out_o == b_in_i, "R2", a_out_o, b_in_i);
      chk(chk_oe_o && chk_ok_o == (par_in_i == ref_par(b_in_i, odd_sel_i)), "R5",
          {7'b0, chk_ok_o}, {7'b0, par_in_i == ref_par(b_in_i, odd_sel_i)});
      chk(!par_oe_o && !b_oe_o, "R7", {6'b0, par_oe_o, b_oe_o}, 8'h0);
    end
    if (en_oe) ;
  endtask

  initial begin
    logic [W-1:0] keep_b;
    logic keep_p;
    void'($urandom(32'd657));
    float_i = 1; dir_tx_i = 0; odd_sel_i = 0; a_in_i = '0; b_in_i = '0; par_in_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset-time state: floating, nothing driven (R3)
    chk({a_oe_o, b_oe_o, par_oe_o, chk_oe_o} == 4'b0, "R3 initial",
        {4'b0, a_oe_o, b_oe_o, par_oe_o, chk_oe_o}, 8'h0);

    // directed corners: empty and full bytes, both senses (R4, R5)
    apply(0, 1, 1, 8'h00, 8'h00, 0);
    chk(par_out_o == 1'b1, "R4 zero ones sel1", {7'b0, par_out_o}, 8'h1);
    apply(0, 1, 0, 8'hFF, 8'h00, 0);
    chk(par_out_o == 1'b0, "R4 eight ones sel0", {7'b0, par_out_o}, 8'h0);
    apply(0, 0, 1, 8'h01, 8'h01, 1);
    chk(chk_ok_o == 1'b0, "R5 odd B sel1 p1 flags error", {7'b0, chk_ok_o}, 8'h0);
    apply(0, 0, 1, 8'h03, 8'h03, 1);
    chk(chk_ok_o == 1'b1, "R5 even B sel1 p1 passes", {7'b0, chk_ok_o}, 8'h1);

    // exhaustive sweep over enable, direction, select, parity in and data
    for (int fl = 0; fl < 2; fl++)
      for (int tx = 0; tx < 2; tx++)
        for (int sel = 0; sel < 2; sel++)
          for (int p = 0; p < 2; p++)
            for (int d = 0; d < 256; d++)
              apply(fl[0], tx[0], sel[0], d[7:0], ~d[7:0] ^ 8'h5A, p[0]);

    // transmit: idle receive inputs must not disturb driven outputs (R6)
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] ob;
      logic op;
      a = $urandom; keep_b = $urandom; keep_p = $urandom;
      apply(0, 1, n[0], a, keep_b, keep_p);
      ob = b_out_o; op = par_out_o;
      apply(0, 1, n[0], a, ~keep_b, ~keep_p);
      chk(b_out_o == ob && par_out_o == op, "R6 rx inputs ignored", {op, b_out_o[6:0]}, {op, ob[6:0]});
    end

    // receive: port A must not disturb driven outputs (R7)
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] ao;
      logic ok;
      keep_b = $urandom; keep_p = $urandom;
      apply(0, 0, n[1], $urandom, keep_b, keep_p);
      ao = a_out_o; ok = chk_ok_o;
      apply(0, 0, n[1], $urandom, keep_b, keep_p);
      chk(a_out_o == ao && chk_ok_o == ok, "R7 port A ignored", a_out_o, ao);
    end

    // random mix, direction and enable flipping together with data (R1..R8)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = $urandom;
      apply(r[3] & r[2], r[1], r[0], $urandom, $urandom, $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule